// File: doc/BRIEF.md
# Cascaded Delay Setting Stepper

This block keeps the delay setting of one byte lane as four cascaded fields. From most to least significant they are coarse, clock delay, tap and phase step. A training sequencer moves the setting one step up or down at a time while it searches for a signal edge. The block carries an increment from a full field into the next field up, and borrows a decrement from the next field up when a field is empty. A step that would pass either end of the range is refused: an error pulse is raised and the setting stays as it was.

The highest tap value depends on the memory clock rate. A two-bit speed input selects it, so the same block can serve every supported rate. A load port writes a starting setting at any time, and a load wins over a step offered in the same cycle.

The step request uses a valid/ready handshake. `step_ready` is low only while `load_en` is high. A step is accepted on a rising clock edge where `step_valid` and `step_ready` are both high, and it takes effect at that same edge. A requester that sees `step_ready` low must keep its request or withdraw it; it is not queued. Load, speed select and the field outputs are plain signals.

Top module: `dstep_stepper`

## Requirements
- R1: After reset every field output is 0 and `step_err` is 0. While `load_en` is 0, `step_ready` is 1.
- R2: An accepted decrement (`step_dir`=0) with phase greater than 0 lowers phase by one and changes no other field.
- R3: An accepted decrement with phase 0 and tap greater than 0 sets phase to 6 and lowers tap by one. Clock delay and coarse are unchanged.
- R4: An accepted decrement with phase and tap at 0 and clock delay greater than 0 sets phase to 6, sets tap to the tap maximum for the selected speed, and lowers clock delay by one.
- R5: An accepted decrement with phase, tap and clock delay all at 0 and coarse greater than 0 sets phase to 6, tap to its maximum and clock delay to 1, and lowers coarse by one.
- R6: An accepted decrement with all four fields at 0 is refused. The setting is unchanged and `step_err` is 1 for exactly the next cycle.
- R7: An accepted increment (`step_dir`=1) raises phase by one below 6. At 6, phase wraps to 0 and carries into tap. Tap at or above its maximum wraps to 0 and carries into clock delay. Clock delay at its limit (default 1) wraps to 0 and carries into coarse.
- R8: An accepted increment with phase 6, tap at its maximum, clock delay at its limit and coarse at its limit (default 3) is refused. The setting is unchanged and `step_err` pulses for one cycle.
- R9: The tap maximum follows `speed_sel`: 0 gives 12 (800 MT/s), 1 gives 10 (1066 MT/s), 2 gives 8 (1333 MT/s), and 3 is treated as 0.
- R10: With `load_en` 1, the load values appear on the field outputs after the next edge. `step_ready` is 0, any step in that cycle is ignored, and `step_err` is 0 in the next cycle.
- R11: A cycle with neither a load nor an accepted step leaves the setting unchanged, and `step_err` is 0 in the next cycle.
- R12: A phase load value above 6 is stored as 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Write the load values this cycle |
| load_coarse | input | 2 | Coarse value to load |
| load_clkd | input | 1 | Clock-delay value to load |
| load_tap | input | 4 | Tap value to load |
| load_pi | input | 3 | Phase value to load (clamped to 6) |
| step_valid | input | 1 | Step request offered |
| step_ready | output | 1 | Step request can be taken |
| step_dir | input | 1 | 1 = increment, 0 = decrement |
| speed_sel | input | 2 | Memory clock rate select |
| coarse | output | 2 | Present coarse field |
| clkd | output | 1 | Present clock-delay field |
| tap | output | 4 | Present tap field |
| pi | output | 3 | Present phase field |
| step_err | output | 1 | One-cycle pulse after a refused step |

## Verification
Some properties are checked on every cycle. Phase never exceeds 6. An error pulse only follows an accepted step, and it leaves the setting unchanged. Idle cycles hold the setting, loads land exactly, and a decrement with phase above 0 touches only phase.

Other behaviour is shown only by the scenarios in the bench. These are the borrow refills into tap and clock delay, the carry chain on increment, and the tap maximum for each speed code. They also cover refusal at both ends of the range, and a load that wins over a step offered in the same cycle.

// File: rtl/dstep_pkg.sv
package dstep_pkg;
  typedef enum logic [1:0] {
    SPD_800  = 2'd0,
    SPD_1066 = 2'd1,
    SPD_1333 = 2'd2,
    SPD_RSVD = 2'd3
  } speed_e;

  localparam int NUM_FIELDS = 4;
  localparam int IDX_PI     = 0;
  localparam int IDX_TAP    = 1;
  localparam int IDX_CLKD   = 2;
  localparam int IDX_COARSE = 3;
endpackage

// File: rtl/dstep_tap_limit.sv
module dstep_tap_limit
  import dstep_pkg::*;
#(
  parameter int TAP_W        = 4,
  parameter int TAP_MAX_800  = 12,
  parameter int TAP_MAX_1066 = 10,
  parameter int TAP_MAX_1333 = 8
) (
  input  logic [1:0]       speed_sel,
  output logic [TAP_W-1:0] tap_max
);
  always_comb begin
    case (speed_e'(speed_sel))
      SPD_1066: tap_max = TAP_W'(TAP_MAX_1066);
      SPD_1333: tap_max = TAP_W'(TAP_MAX_1333);
      default:  tap_max = TAP_W'(TAP_MAX_800);
    endcase
  end
endmodule

// File: rtl/dstep_field.sv
module dstep_field #(
  parameter int FW = 4
) (
  input  logic          en,
  input  logic          inc,
  input  logic [FW-1:0] cur,
  input  logic [FW-1:0] lim,
  input  logic [FW-1:0] refill,
  output logic [FW-1:0] nxt,
  output logic          wrap
);
  always_comb begin
    nxt  = cur;
    wrap = 1'b0;
    if (en) begin
      if (inc) begin
        if (cur >= lim) begin
          nxt  = '0;
          wrap = 1'b1;
        end else begin
          nxt = cur + 1'b1;
        end
      end else begin
        if (cur == '0) begin
          nxt  = refill;
          wrap = 1'b1;
        end else begin
          nxt = cur - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dstep_cascade.sv
module dstep_cascade
  import dstep_pkg::*;
#(
  parameter int FW = 4
) (
  input  logic          inc,
  input  logic [FW-1:0] cur    [NUM_FIELDS],
  input  logic [FW-1:0] lim    [NUM_FIELDS],
  input  logic [FW-1:0] refill [NUM_FIELDS],
  output logic [FW-1:0] nxt    [NUM_FIELDS],
  output logic          refused
);
  logic [NUM_FIELDS:0] chain;

  assign chain[0] = 1'b1;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    dstep_field #(.FW(FW)) u_field (
      .en     (chain[g]),
      .inc    (inc),
      .cur    (cur[g]),
      .lim    (lim[g]),
      .refill (refill[g]),
      .nxt    (nxt[g]),
      .wrap   (chain[g+1])
    );
  end

  assign refused = chain[NUM_FIELDS];
endmodule

// File: rtl/dstep_stepper.sv
module dstep_stepper
  import dstep_pkg::*;
#(
  parameter int COARSE_W     = 2,
  parameter int CLKD_W       = 1,
  parameter int TAP_W        = 4,
  parameter int PI_W         = 3,
  parameter int PI_MAX       = 6,
  parameter int COARSE_MAX   = 3,
  parameter int CLKD_MAX     = 1,
  parameter int CLKD_REFILL  = 1,
  parameter int TAP_MAX_800  = 12,
  parameter int TAP_MAX_1066 = 10,
  parameter int TAP_MAX_1333 = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_en,
  input  logic [COARSE_W-1:0] load_coarse,
  input  logic [CLKD_W-1:0]   load_clkd,
  input  logic [TAP_W-1:0]    load_tap,
  input  logic [PI_W-1:0]     load_pi,
  input  logic                step_valid,
  output logic                step_ready,
  input  logic                step_dir,
  input  logic [1:0]          speed_sel,
  output logic [COARSE_W-1:0] coarse,
  output logic [CLKD_W-1:0]   clkd,
  output logic [TAP_W-1:0]    tap,
  output logic [PI_W-1:0]     pi,
  output logic                step_err
);
  localparam int FW_A = (COARSE_W > CLKD_W) ? COARSE_W : CLKD_W;
  localparam int FW_B = (TAP_W > PI_W) ? TAP_W : PI_W;
  localparam int FW   = (FW_A > FW_B) ? FW_A : FW_B;

  logic [COARSE_W-1:0] coarse_q;
  logic [CLKD_W-1:0]   clkd_q;
  logic [TAP_W-1:0]    tap_q;
  logic [PI_W-1:0]     pi_q;
  logic                err_q;

  logic [TAP_W-1:0] tap_max;
  logic [FW-1:0]    cur_a [NUM_FIELDS];
  logic [FW-1:0]    lim_a [NUM_FIELDS];
  logic [FW-1:0]    ref_a [NUM_FIELDS];
  logic [FW-1:0]    nxt_a [NUM_FIELDS];
  logic             refused;
  logic             step_take;
  logic [PI_W-1:0]  pi_load_clamped;

  dstep_tap_limit #(
    .TAP_W        (TAP_W),
    .TAP_MAX_800  (TAP_MAX_800),
    .TAP_MAX_1066 (TAP_MAX_1066),
    .TAP_MAX_1333 (TAP_MAX_1333)
  ) u_tap_limit (
    .speed_sel (speed_sel),
    .tap_max   (tap_max)
  );

  always_comb begin
    cur_a[IDX_PI]     = FW'(pi_q);
    cur_a[IDX_TAP]    = FW'(tap_q);
    cur_a[IDX_CLKD]   = FW'(clkd_q);
    cur_a[IDX_COARSE] = FW'(coarse_q);
    lim_a[IDX_PI]     = FW'(PI_MAX);
    lim_a[IDX_TAP]    = FW'(tap_max);
    lim_a[IDX_CLKD]   = FW'(CLKD_MAX);
    lim_a[IDX_COARSE] = FW'(COARSE_MAX);
    ref_a[IDX_PI]     = FW'(PI_MAX);
    ref_a[IDX_TAP]    = FW'(tap_max);
    ref_a[IDX_CLKD]   = FW'(CLKD_REFILL);
    ref_a[IDX_COARSE] = '0;
  end

  dstep_cascade #(.FW(FW)) u_cascade (
    .inc     (step_dir),
    .cur     (cur_a),
    .lim     (lim_a),
    .refill  (ref_a),
    .nxt     (nxt_a),
    .refused (refused)
  );

  assign step_ready      = !load_en;
  assign step_take       = step_valid && step_ready;
  assign pi_load_clamped = (load_pi > PI_W'(PI_MAX)) ? PI_W'(PI_MAX) : load_pi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coarse_q <= '0;
      clkd_q   <= '0;
      tap_q    <= '0;
      pi_q     <= '0;
      err_q    <= 1'b0;
    end else if (load_en) begin
      coarse_q <= load_coarse;
      clkd_q   <= load_clkd;
      tap_q    <= load_tap;
      pi_q     <= pi_load_clamped;
      err_q    <= 1'b0;
    end else if (step_take) begin
      err_q <= refused;
      if (!refused) begin
        coarse_q <= nxt_a[IDX_COARSE][COARSE_W-1:0];
        clkd_q   <= nxt_a[IDX_CLKD][CLKD_W-1:0];
        tap_q    <= nxt_a[IDX_TAP][TAP_W-1:0];
        pi_q     <= nxt_a[IDX_PI][PI_W-1:0];
      end
    end else begin
      err_q <= 1'b0;
    end
  end

  assign coarse   = coarse_q;
  assign clkd     = clkd_q;
  assign tap      = tap_q;
  assign pi       = pi_q;
  assign step_err = err_q;
endmodule

// File: rtl/dstep_checker.sv
module dstep_checker #(
  parameter int COARSE_W = 2,
  parameter int CLKD_W   = 1,
  parameter int TAP_W    = 4,
  parameter int PI_W     = 3,
  parameter int PI_MAX   = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                load_en,
  input logic [COARSE_W-1:0] load_coarse,
  input logic [CLKD_W-1:0]   load_clkd,
  input logic [TAP_W-1:0]    load_tap,
  input logic                step_valid,
  input logic                step_dir,
  input logic [COARSE_W-1:0] coarse,
  input logic [CLKD_W-1:0]   clkd,
  input logic [TAP_W-1:0]    tap,
  input logic [PI_W-1:0]     pi,
  input logic                step_err
);
  assert_pi_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pi <= PI_W'(PI_MAX));

  assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_err |-> $past(step_valid && !load_en));

  assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_err |-> ($stable(coarse) && $stable(clkd) && $stable(tap) && $stable(pi)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !step_valid) |=>
      ($stable(coarse) && $stable(clkd) && $stable(tap) && $stable(pi) && !step_err));

  assert_load_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (coarse == $past(load_coarse) && clkd == $past(load_clkd) &&
                 tap == $past(load_tap) && !step_err));

  assert_dec_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !load_en && !step_dir && pi != '0) |=>
      (pi == PI_W'($past(pi) - 1'b1) && $stable(tap) && $stable(clkd) && $stable(coarse)));
endmodule

bind dstep_stepper dstep_checker #(
  .COARSE_W (COARSE_W),
  .CLKD_W   (CLKD_W),
  .TAP_W    (TAP_W),
  .PI_W     (PI_W),
  .PI_MAX   (PI_MAX)
) u_dstep_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_en     (load_en),
  .load_coarse (load_coarse),
  .load_clkd   (load_clkd),
  .load_tap    (load_tap),
  .step_valid  (step_valid),
  .step_dir    (step_dir),
  .coarse      (coarse),
  .clkd        (clkd),
  .tap         (tap),
  .pi          (pi),
  .step_err    (step_err)
);

// File: tb/dstep_stepper_test.sv
module dstep_stepper_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int    c;
    int    d;
    int    t;
    int    p;
    int    e;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_en = 1'b0;
  logic [1:0] load_coarse = '0;
  logic [0:0] load_clkd = '0;
  logic [3:0] load_tap = '0;
  logic [2:0] load_pi = '0;
  logic       step_valid = 1'b0;
  logic       step_ready;
  logic       step_dir = 1'b0;
  logic [1:0] speed_sel = '0;
  logic [1:0] coarse;
  logic [0:0] clkd;
  logic [3:0] tap;
  logic [2:0] pi;
  logic       step_err;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  exp_t sb_q[$];
  int   mc = 0, md = 0, mt = 0, mp = 0;

  dstep_stepper uut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_coarse(load_coarse),
    .load_clkd(load_clkd), .load_tap(load_tap), .load_pi(load_pi),
    .step_valid(step_valid), .step_ready(step_ready), .step_dir(step_dir),
    .speed_sel(speed_sel), .coarse(coarse), .clkd(clkd), .tap(tap), .pi(pi),
    .step_err(step_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int tmax(int s);
    if (s == 1) return 10;
    if (s == 2) return 8;
    return 12;
  endfunction

  task automatic expect_eq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic op(string tag, bit ld, int lc, int ldd, int lt, int lp,
                    bit sv, bit dir, int spd);
    exp_t x;
    int   e = 0;
    int   tm;
    @(negedge clk);
    load_en     = ld;
    load_coarse = lc[1:0];
    load_clkd   = ldd[0:0];
    load_tap    = lt[3:0];
    load_pi     = lp[2:0];
    step_valid  = sv;
    step_dir    = dir;
    speed_sel   = spd[1:0];
    #1;
    expect_eq("R11", "step_ready", int'(step_ready), ld ? 0 : 1);
    tm = tmax(spd);
    if (ld) begin
      mc = lc; md = ldd; mt = lt; mp = (lp > 6) ? 6 : lp;
    end else if (sv) begin
      if (dir) begin
        if (mp < 6) mp++;
        else if (mt < tm) begin mp = 0; mt++; end
        else if (md < 1) begin mp = 0; mt = 0; md++; end
        else if (mc < 3) begin mp = 0; mt = 0; md = 0; mc++; end
        else e = 1;
      end else begin
        if (mp > 0) mp--;
        else if (mt > 0) begin mp = 6; mt--; end
        else if (md > 0) begin mp = 6; mt = tm; md--; end
        else if (mc > 0) begin mp = 6; mt = tm; md = 1; mc--; end
        else e = 1;
      end
    end
    x.c = mc; x.d = md; x.t = mt; x.p = mp; x.e = e; x.tag = tag;
    sb_q.push_back(x);
  endtask

  initial begin : monitor
    exp_t x;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb_q.size() > 0) begin
        x = sb_q.pop_front();
        expect_eq(x.tag, "coarse", int'(coarse), x.c);
        expect_eq(x.tag, "clkd", int'(clkd), x.d);
        expect_eq(x.tag, "tap", int'(tap), x.t);
        expect_eq(x.tag, "pi", int'(pi), x.p);
        expect_eq(x.tag, "step_err", int'(step_err), x.e);
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD*20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    expect_eq("R1", "coarse", int'(coarse), 0);
    expect_eq("R1", "clkd", int'(clkd), 0);
    expect_eq("R1", "tap", int'(tap), 0);
    expect_eq("R1", "pi", int'(pi), 0);
    expect_eq("R1", "step_err", int'(step_err), 0);
    expect_eq("R1", "step_ready", int'(step_ready), 1);

    // R2 phase-only decrement
    op("R10", 1, 1, 1, 5, 3, 0, 0, 0);
    for (int i = 0; i < 3; i++) op("R2", 0, 0, 0, 0, 0, 1, 0, 0);
    // R3 borrow from tap
    op("R3", 0, 0, 0, 0, 0, 1, 0, 0);
    // R6 refusal at zero
    op("R10", 1, 0, 0, 0, 0, 0, 0, 0);
    op("R6", 0, 0, 0, 0, 0, 1, 0, 0);
    op("R11", 0, 0, 0, 0, 0, 0, 0, 0);
    op("R3", 1, 0, 0, 2, 0, 0, 0, 0);
    op("R3", 0, 0, 0, 0, 0, 1, 0, 0);
    // R4 and R9 refill tap per speed
    for (int s = 0; s < 4; s++) begin
      op("R9", 1, 0, 1, 0, 0, 0, 0, s);
      op("R4", 0, 0, 0, 0, 0, 1, 0, s);
    end
    // R5 borrow from coarse sets clock delay to 1
    op("R5", 1, 2, 0, 0, 0, 0, 0, 0);
    op("R5", 0, 0, 0, 0, 0, 1, 0, 0);
    op("R5", 1, 1, 0, 0, 0, 0, 0, 2);
    op("R5", 0, 0, 0, 0, 0, 1, 0, 2);
    // R7 carries on increment
    op("R7", 1, 0, 0, 0, 5, 0, 1, 0);
    op("R7", 0, 0, 0, 0, 0, 1, 1, 0);
    op("R7", 0, 0, 0, 0, 0, 1, 1, 0);
    op("R7", 1, 0, 0, 12, 6, 0, 1, 0);
    op("R7", 0, 0, 0, 0, 0, 1, 1, 0);
    op("R7", 1, 0, 1, 12, 6, 0, 1, 0);
    op("R7", 0, 0, 0, 0, 0, 1, 1, 0);
    op("R9", 1, 0, 0, 8, 6, 0, 1, 2);
    op("R9", 0, 0, 0, 0, 0, 1, 1, 2);
    // R8 refusal at top
    op("R8", 1, 3, 1, 12, 6, 0, 1, 0);
    op("R8", 0, 0, 0, 0, 0, 1, 1, 0);
    op("R11", 0, 0, 0, 0, 0, 0, 1, 0);
    op("R8", 1, 3, 1, 8, 6, 0, 1, 2);
    op("R8", 0, 0, 0, 0, 0, 1, 1, 2);
    // R10 load wins over step in the same cycle
    op("R10", 1, 2, 1, 7, 4, 1, 0, 0);
    op("R10", 1, 0, 0, 0, 0, 1, 0, 0);
    // R12 phase load clamp
    op("R12", 1, 1, 0, 3, 7, 0, 0, 0);
    op("R11", 0, 0, 0, 0, 0, 0, 0, 0);
    op("R11", 0, 0, 0, 0, 0, 0, 1, 1);

    @(negedge clk);
    load_en    = 1'b0;
    step_valid = 1'b0;
    repeat (3) @(negedge clk);
    expect_eq("R11", "scoreboard drained", sb_q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule